// File: doc/BRIEF.md
# DRAM Strobe Decoder with Refresh Row Counter

This block models the device side of an EDO DRAM in synthesizable form. Every clock it samples the active-low row strobe, the two column strobes (one per byte lane), the write and output enables, and the multiplexed address. It compares each sample with the one before it to find strobe edges. From the order of those edges it classifies each cycle as one of the following: row activation, RAS-only refresh, CAS-before-RAS refresh, hidden refresh, word or byte read, word or byte write, or a page-mode access. It then drives a small parameterised array.

A RAS fall with both column strobes high latches the row from the address pins. Column-strobe falls while that row is held select a column and perform the access. A RAS fall with a column strobe already low is a refresh, and its row comes from an internal 10-bit counter instead of the pins. Read data follows extended-data-out rules: it stays driven after the column strobe rises, and is released only when the row strobe and that lane's column strobe are both high, or while the output enable is high. The decoded operation code and refresh row are also reported, so the block can serve as a checker beside a memory controller.

Top module: `dramStrobeDecoder`

## Requirements
- R1: After reset, opCode is 0 (idle), dataOe is 00, errFlag is 0, and the first counter-sourced refresh uses row 0.
- R2: A clock edge that samples rasN, ucasN and lcasN all high leaves dataOe at 00 after that edge.
- R3: A RAS fall sampled with both column strobes high latches the row from addr. For one cycle opCode becomes 7 and refreshRow equals that address, and dataOe stays 00.
- R4: A RAS fall sampled with at least one column strobe low, with weN high and no lane driving, gives opCode 8 for one cycle. refreshRow then equals the internal counter and addr is ignored. The counter then advances by one and wraps from 1023 to 0.
- R5: A RAS fall sampled with a column strobe still low after a read, while that lane still drives, gives opCode 9. It uses and advances the same counter, and dataOe and dataOut keep the read data.
- R6: A column-strobe fall with weN high in an open row returns the stored word at {row, column}. Lane 0 (bits 7:0) follows lcasN and lane 1 (bits 15:8) follows ucasN. dataOe is set for each lane whose strobe is low, and opCode is 1 when both lanes are selected and 2 when only one is.
- R7: A column-strobe fall with weN low in an open row writes dataIn into the lanes whose strobe is low and leaves the other lane unchanged. opCode is 3 for a full word and 4 for a single byte.
- R8: Second and later column-strobe falls within one RAS-low period reuse the latched row and take only the column from addr. opCode is 5 for a read and 6 for a write.
- R9: Read data stays driven after the column strobe rises while rasN is low. oeN high forces dataOe to 00 at once.
- R10: A RAS fall sampled with a column strobe low and weN low raises errFlag for one cycle with opCode 0. It writes nothing and leaves the counter unchanged.
- R11: Column-strobe falls while rasN is high (no open row) neither read nor write, and opCode stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| ucasN | input | 1 | Column strobe for lane 1 (bits 15:8), active low |
| lcasN | input | 1 | Column strobe for lane 0 (bits 7:0), active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dataIn | input | 2*LANE_W | Write data |
| dataOut | output | 2*LANE_W | Read data register |
| dataOe | output | 2 | Per-lane drive enable for dataOut |
| opCode | output | 4 | Operation decoded this cycle (one-cycle event, 0 otherwise) |
| refreshRow | output | REF_W | Row refreshed by the last refresh or activation event |
| errFlag | output | 1 | One-cycle flag for an undefined RAS-fall combination |

## Verification
The bench builds the block with ADDR_W = 4, LANE_W = 8 and REF_W = 10. That gives a 256-word array that can be written entirely and then read back through random page and byte accesses. With these values, more than 1024 counter-sourced refreshes fit easily in the run, so the counter wrap from 1023 to 0 is reached and compared. Random mixes of activations, page bursts, CBR, hidden and illegal sequences are interleaved. Because of this, stray writes from ignored strobes or error cycles show up as read mismatches later.

// File: rtl/dramPkg.sv
package dramPkg;

  typedef enum logic [3:0] {
    OP_IDLE    = 4'd0,
    OP_READ    = 4'd1,
    OP_BREAD   = 4'd2,
    OP_WRITE   = 4'd3,
    OP_BWRITE  = 4'd4,
    OP_PREAD   = 4'd5,
    OP_PWRITE  = 4'd6,
    OP_ROWOPEN = 4'd7,
    OP_CBR     = 4'd8,
    OP_HIDDEN  = 4'd9
  } dramOp_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_REF  = 2'd2
  } cycState_e;

  // Strobes from control to the array datapath.
  typedef struct packed {
    logic       rdEn;
    logic       wrEn;
    logic [1:0] laneMask;  // bit 0 = low byte lane, bit 1 = high byte lane
  } arrayStrb_t;

endpackage

// File: rtl/dramCtrl.sv
module dramCtrl
  import dramPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REF_W  = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rasN,
  input  logic                  ucasN,
  input  logic                  lcasN,
  input  logic                  weN,
  input  logic [ADDR_W-1:0]     addr,
  output arrayStrb_t            strb,
  output logic [2*ADDR_W-1:0]   arrIdx,
  output dramOp_e               opCode,
  output logic [REF_W-1:0]      refreshRow,
  output logic                  errFlag,
  output logic [1:0]            laneDrive
);

  localparam int LANES = 2;

  logic             rasQ;
  logic [LANES-1:0] casQ;
  logic [LANES-1:0] casNow;
  logic [LANES-1:0] casLow;
  logic             rasFall;
  logic             casFallAny;
  cycState_e        state;
  logic [ADDR_W-1:0] rowQ;
  logic             colSeen;
  logic [REF_W-1:0] refCnt;

  assign casNow     = {ucasN, lcasN};
  assign casLow     = ~casNow;
  assign rasFall    = rasQ & ~rasN;
  assign casFallAny = |(casQ & casLow);

  // Column access strobes toward the array.
  always_comb begin
    strb   = '0;
    arrIdx = {rowQ, addr};
    if (state == ST_ROW && !rasN && casFallAny) begin
      strb.laneMask = casLow;
      strb.rdEn     = weN;
      strb.wrEn     = ~weN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasQ       <= 1'b1;
      casQ       <= '1;
      state      <= ST_IDLE;
      rowQ       <= '0;
      colSeen    <= 1'b0;
      refCnt     <= '0;
      opCode     <= OP_IDLE;
      refreshRow <= '0;
      errFlag    <= 1'b0;
      laneDrive  <= '0;
    end else begin
      rasQ    <= rasN;
      casQ    <= casNow;
      opCode  <= OP_IDLE;
      errFlag <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (rasN && casNow[l]) laneDrive[l] <= 1'b0;
      end
      if (rasFall) begin
        if (&casNow) begin
          state      <= ST_ROW;
          rowQ       <= addr;
          colSeen    <= 1'b0;
          opCode     <= OP_ROWOPEN;
          refreshRow <= REF_W'(addr);
        end else if (!weN) begin
          state   <= ST_REF;
          errFlag <= 1'b1;
        end else begin
          state      <= ST_REF;
          refreshRow <= refCnt;
          refCnt     <= refCnt + 1'b1;
          opCode     <= (|laneDrive) ? OP_HIDDEN : OP_CBR;
        end
      end else if (rasN) begin
        state   <= ST_IDLE;
        colSeen <= 1'b0;
      end else if (strb.rdEn || strb.wrEn) begin
        colSeen <= 1'b1;
        if (strb.rdEn) begin
          laneDrive <= casLow;
          opCode    <= colSeen ? OP_PREAD : ((&casLow) ? OP_READ : OP_BREAD);
        end else begin
          laneDrive <= '0;
          opCode    <= colSeen ? OP_PWRITE : ((&casLow) ? OP_WRITE : OP_BWRITE);
        end
      end
    end
  end

endmodule

// File: rtl/dramArray.sv
module dramArray
  import dramPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  arrayStrb_t            strb,
  input  logic [2*ADDR_W-1:0]   idx,
  input  logic [2*LANE_W-1:0]   wrData,
  output logic [2*LANE_W-1:0]   rdData
);

  localparam int DEPTH = 1 << (2 * ADDR_W);
  localparam int LANES = 2;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneRd;

    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.laneMask[g]) laneMem[idx] <= wrData[g*LANE_W +: LANE_W];
      if (strb.rdEn && strb.laneMask[g]) laneRd <= laneMem[idx];
    end

    assign rdData[g*LANE_W +: LANE_W] = laneRd;
  end

endmodule

// File: rtl/dramStrobeDecoder.sv
module dramStrobeDecoder
  import dramPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8,
  parameter int REF_W  = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rasN,
  input  logic                  ucasN,
  input  logic                  lcasN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   dataIn,
  output logic [2*LANE_W-1:0]   dataOut,
  output logic [1:0]            dataOe,
  output logic [3:0]            opCode,
  output logic [REF_W-1:0]      refreshRow,
  output logic                  errFlag
);

  arrayStrb_t            ctrlStrb;
  logic [2*ADDR_W-1:0]   arrIdx;
  dramOp_e               opEvt;
  logic [1:0]            laneDrive;

  dramCtrl #(.ADDR_W(ADDR_W), .REF_W(REF_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rasN       (rasN),
    .ucasN      (ucasN),
    .lcasN      (lcasN),
    .weN        (weN),
    .addr       (addr),
    .strb       (ctrlStrb),
    .arrIdx     (arrIdx),
    .opCode     (opEvt),
    .refreshRow (refreshRow),
    .errFlag    (errFlag),
    .laneDrive  (laneDrive)
  );

  dramArray #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) uArray (
    .clk    (clk),
    .strb   (ctrlStrb),
    .idx    (arrIdx),
    .wrData (dataIn),
    .rdData (dataOut)
  );

  assign opCode = opEvt;
  assign dataOe = laneDrive & {2{~oeN}};

endmodule

// File: rtl/dramChecker.sv
module dramChecker
  import dramPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REF_W  = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               rasN,
  input logic               ucasN,
  input logic               lcasN,
  input logic [ADDR_W-1:0]  addr,
  input logic [3:0]         opCode,
  input logic [REF_W-1:0]   refreshRow,
  input logic               errFlag,
  input logic [1:0]         dataOe,
  input arrayStrb_t         strb
);

  logic [REF_W-1:0] lastRef;
  logic             seenRef;
  logic             refEvt;

  assign refEvt = (opCode == OP_CBR) || (opCode == OP_HIDDEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRef <= '0;
      seenRef <= 1'b0;
    end else if (refEvt) begin
      lastRef <= refreshRow;
      seenRef <= 1'b1;
    end
  end

  p_standby_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rasN && ucasN && lcasN) |-> dataOe == 2'b00);

  p_rowopen_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_ROWOPEN) |-> refreshRow == REF_W'($past(addr)));

  p_counter_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (refEvt && seenRef) |-> refreshRow == lastRef + REF_W'(1));

  p_read_reports_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> (opCode == OP_READ || opCode == OP_BREAD || opCode == OP_PREAD));

  p_write_reports_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (opCode == OP_WRITE || opCode == OP_BWRITE || opCode == OP_PWRITE));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> opCode == OP_IDLE);

endmodule

bind dramStrobeDecoder dramChecker #(.ADDR_W(ADDR_W), .REF_W(REF_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .rasN       (rasN),
  .ucasN      (ucasN),
  .lcasN      (lcasN),
  .addr       (addr),
  .opCode     (opCode),
  .refreshRow (refreshRow),
  .errFlag    (errFlag),
  .dataOe     (dataOe),
  .strb       (ctrlStrb)
);

// File: tb/tb_dramStrobeDecoder.sv
module tb_dramStrobeDecoder;

  localparam int ADDR_W = 4;
  localparam int LANE_W = 8;
  localparam int REF_W  = 10;
  localparam int ROWS   = 1 << ADDR_W;
  localparam int WORDS  = ROWS * ROWS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, ucasN = 1'b1, lcasN = 1'b1, weN = 1'b1, oeN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [2*LANE_W-1:0] dataIn = '0;
  logic [2*LANE_W-1:0] dataOut;
  logic [1:0] dataOe;
  logic [3:0] opCode;
  logic [REF_W-1:0] refreshRow;
  logic errFlag;

  int checks = 0;
  int fails = 0;
  int expCnt = 0;
  logic [15:0] refMem [WORDS];
  int curRow = 0;

  always #4 clk = ~clk;

  dramStrobeDecoder #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .REF_W(REF_W)) dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .ucasN(ucasN), .lcasN(lcasN),
    .weN(weN), .oeN(oeN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .opCode(opCode), .refreshRow(refreshRow), .errFlag(errFlag)
  );

  function automatic logic [15:0] laneBits(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [3:0] expOp(input bit wr, input bit first, input logic [1:0] m);
    if (!first) return wr ? 4'd6 : 4'd5;
    if (wr) return (m == 2'b11) ? 4'd3 : 4'd4;
    return (m == 2'b11) ? 4'd1 : 4'd2;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rowOpen(input int row);
    addr = ADDR_W'(row); rasN = 1'b0; curRow = row;
    tick();
    chk("R3", "rowopen op", opCode, 4'd7);
    chk("R3", "rowopen row", refreshRow, row);
    chk("R3", "rowopen oe", dataOe, 2'b00);
  endtask

  task automatic rowClose();
    rasN = 1'b1; ucasN = 1'b1; lcasN = 1'b1; weN = 1'b1;
    tick();
    chk("R2", "standby oe", dataOe, 2'b00);
  endtask

  task automatic colAccess(input int col, input logic [1:0] m, input bit wr, input bit first);
    int idx;
    logic [15:0] d;
    idx = curRow * ROWS + col;
    d = 16'($urandom);
    addr = ADDR_W'(col); lcasN = ~m[0]; ucasN = ~m[1]; weN = ~wr; dataIn = d;
    tick();
    chk(first ? (wr ? "R7" : "R6") : "R8", "access op", opCode, expOp(wr, first, m));
    if (wr) begin
      refMem[idx] = (refMem[idx] & ~laneBits(m)) | (d & laneBits(m));
      chk("R7", "write no drive", dataOe, 2'b00);
    end else begin
      chk("R6", "read oe", dataOe, m);
      chk("R6", "read data", dataOut & laneBits(m), refMem[idx] & laneBits(m));
    end
    lcasN = 1'b1; ucasN = 1'b1; weN = 1'b1;
    tick();
    if (!wr) begin
      chk("R9", "edo hold oe", dataOe, m);
      chk("R9", "edo hold data", dataOut & laneBits(m), refMem[idx] & laneBits(m));
    end
  endtask

  task automatic cbr(input logic [1:0] m);
    lcasN = ~m[0]; ucasN = ~m[1]; weN = 1'b1;
    tick();
    chk("R11", "cas with ras high", opCode, 4'd0);
    addr = ADDR_W'($urandom); rasN = 1'b0;
    tick();
    chk("R4", "cbr op", opCode, 4'd8);
    chk("R4", "cbr row", refreshRow, expCnt);
    expCnt = (expCnt + 1) % 1024;
    rasN = 1'b1; lcasN = 1'b1; ucasN = 1'b1;
    tick();
  endtask

  task automatic errCase(input logic [1:0] m);
    lcasN = ~m[0]; ucasN = ~m[1]; weN = 1'b0; dataIn = 16'($urandom);
    addr = ADDR_W'($urandom);
    tick();
    chk("R11", "write with ras high", opCode, 4'd0);
    rasN = 1'b0;
    tick();
    chk("R10", "err flag", errFlag, 1'b1);
    chk("R10", "err op", opCode, 4'd0);
    rasN = 1'b1; lcasN = 1'b1; ucasN = 1'b1; weN = 1'b1;
    tick();
    chk("R10", "err clears", errFlag, 1'b0);
  endtask

  task automatic hiddenRef(input int row, input int col, input logic [1:0] m);
    int idx;
    idx = row * ROWS + col;
    rowOpen(row);
    addr = ADDR_W'(col); lcasN = ~m[0]; ucasN = ~m[1]; weN = 1'b1;
    tick();
    chk("R6", "pre-hidden read", dataOut & laneBits(m), refMem[idx] & laneBits(m));
    rasN = 1'b1;
    tick();
    chk("R5", "held while ras high", dataOe, m);
    oeN = 1'b1;
    #1;
    chk("R9", "oe high blanks", dataOe, 2'b00);
    oeN = 1'b0;
    addr = ADDR_W'($urandom); rasN = 1'b0;
    tick();
    chk("R5", "hidden op", opCode, 4'd9);
    chk("R5", "hidden row", refreshRow, expCnt);
    chk("R5", "hidden oe", dataOe, m);
    chk("R5", "hidden data", dataOut & laneBits(m), refMem[idx] & laneBits(m));
    expCnt = (expCnt + 1) % 1024;
    rowClose();
  endtask

  function automatic logic [1:0] randMask();
    logic [1:0] m;
    m = 2'($urandom_range(1, 3));
    return m;
  endfunction

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset op", opCode, 4'd0);
    chk("R1", "reset oe", dataOe, 2'b00);
    chk("R1", "reset err", errFlag, 1'b0);

    // First counter refresh after reset uses row 0 (R1)
    cbr(2'b11);

    // Fill the array with full-word page writes
    for (int r = 0; r < ROWS; r++) begin
      rowOpen(r);
      for (int c = 0; c < ROWS; c++) colAccess(c, 2'b11, 1'b1, c == 0);
      rowClose();
    end

    // Directed: byte write keeps other lane, then byte reads
    rowOpen(5);
    colAccess(3, 2'b01, 1'b1, 1'b1);
    colAccess(3, 2'b10, 1'b0, 1'b0);
    colAccess(3, 2'b01, 1'b0, 1'b0);
    colAccess(3, 2'b11, 1'b0, 1'b0);
    rowClose();
    rowOpen(9);
    rowClose();
    hiddenRef(2, 7, 2'b11);
    hiddenRef(4, 1, 2'b10);
    errCase(2'b01);
    cbr(2'b10);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int kind;
      kind = $urandom_range(0, 5);
      case (kind)
        0, 1: begin
          int n;
          bit wr;
          rowOpen($urandom_range(0, ROWS - 1));
          n = $urandom_range(1, 4);
          wr = 1'($urandom);
          for (int k = 0; k < n; k++)
            colAccess($urandom_range(0, ROWS - 1), randMask(), wr, k == 0);
          rowClose();
        end
        2: cbr(randMask());
        3: begin rowOpen($urandom_range(0, ROWS - 1)); rowClose(); end
        4: hiddenRef($urandom_range(0, ROWS - 1), $urandom_range(0, ROWS - 1), randMask());
        default: errCase(randMask());
      endcase
    end

    // Drive the counter through its wrap (R4)
    for (int k = 0; k < 1030; k++) cbr(randMask());

    // Final readback confirms ignored strobes and error cycles wrote nothing
    for (int r = 0; r < ROWS; r++) begin
      rowOpen(r);
      for (int c = 0; c < ROWS; c++) colAccess(c, 2'b11, 1'b0, c == 0);
      rowClose();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule